// File: doc/BRIEF.md
# Complex Half-Precision Floating-Point Multiplier

This block computes the product of two complex numbers whose real and imaginary parts are 16-bit binary floating-point values. The format has 1 sign bit, 5 exponent bits with bias 15, and 10 fraction bits. A caller places both operands and a rounding mode on the inputs and pulses `start`. The block then works through the four cross products and the two sums one step at a time. It uses a single half-precision multiplier and a single adder/subtractor, and at no point does it convert to fixed point.

Each partial product adds the two exponents and removes the bias. It multiplies the two 11-bit significands into a 22-bit product, truncates that product to 11 bits plus guard and sticky, rounds under the selected mode and packs the result. The real part is then formed as ac − bd and the imaginary part as ad + bc, and each of these is rounded again. The block raises a one-cycle `done` when the packed result and the accumulated exception flags are ready.

Top module: `cplx_hmul`

## Requirements
- R1: Operand packing. `op_x[31:16]` holds a (real) and `op_x[15:0]` holds b (imaginary), and `op_y` holds c and d the same way. `result[31:16]` is the real part and `result[15:0]` is the imaginary part. Each half holds the sign in bit 15, the exponent in bits 14:10 (bias 15) and the fraction in bits 9:0.
- R2: The result is real = ac − bd and imaginary = ad + bc. For example, (6 + j5)·(10 + j4.5) gives 0x50B0_54D0 (37.5 + j77). Adding a zero operand returns the other operand exactly.
- R3: `rnd_mode` selects the rounding: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward −infinity. Rounding is applied to every partial product and again after the add/subtract. An exact zero sum of operands with opposite signs is −0 under mode 11 and +0 under every other mode.
- R4: The sign of each partial product is the XOR of its two input signs, including zero products.
- R5: Infinity times zero in any partial product gives the quiet NaN 0x7E00 and raises invalid. A NaN input to either stage gives 0x7E00 without raising invalid.
- R6: A product whose exponent after rounding is below 1 is flushed to a signed zero and raises underflow and inexact. Subnormal inputs (exponent field 0) are treated as zero.
- R7: A result whose exponent reaches 31 raises overflow and inexact. It becomes infinity under nearest-even, and also under a directed mode that points away from zero for that sign. Otherwise it becomes the largest finite value 0x7BFF with the result's sign.
- R8: `flags` holds invalid in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0. It is the OR over all six operations of one request. `flags` and `result` change only in the cycle in which `done` is raised.
- R9: `done` is high for exactly one cycle. It rises 6 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises.
- R10: A `start` while `busy` is high is ignored. The operation in flight finishes with its own operands, and the ignored start produces no extra `done`.
- R11: A synchronous active-low reset clears `busy`, `done`, `result` and `flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted only when idle |
| op_x | input | 32 | First complex operand {a, b} |
| op_y | input | 32 | Second complex operand {c, d} |
| rnd_mode | input | 2 | Rounding mode for this request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Packed complex product {real, imag} |
| flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The product is tried with integer-valued operands whose partial products and sums are exact, with unit and pure-imaginary operands, and with mixed signs. These cases separate a swapped cross term, a wrong add/subtract and a wrong product sign. Operands of 1 + 2⁻¹⁰ squared, and sums that leave an exact tie at the guard bit, are run under each rounding mode. This shows whether rounding happens in the multiplier, in the adder, or in both. Extreme exponents, infinity times zero, NaN and subnormal inputs exercise each flag and flush path on its own. A start that arrives while busy shows whether the in-flight operands are held.

// File: rtl/cplx_hmul_pkg.sv
// Shared types, format constants and the rounding/packing helper for the
// complex half-precision multiplier. Assumes binary16-style fields.
package cplx_hmul_pkg;

    parameter int EXP_W  = 5;
    parameter int FRAC_W = 10;

    localparam int HW     = 1 + EXP_W + FRAC_W;           // one half value
    localparam int SIG_W  = FRAC_W + 1;                   // with hidden bit
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EXPS_W = EXP_W + 3;                    // signed work exponent
    localparam int ALN_W  = 2 * SIG_W + 2;                // adder alignment width
    localparam int LZ_W   = $clog2(ALN_W + 1);

    typedef logic [HW-1:0]            half_t;
    typedef logic signed [EXPS_W-1:0] sexp_t;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_POS  = 2'b10,
        RND_NEG  = 2'b11
    } rmode_e;

    typedef struct packed {
        logic nv;   // invalid
        logic of;   // overflow
        logic uf;   // underflow
        logic nx;   // inexact
    } hflags_t;

    typedef struct packed {
        half_t   val;
        hflags_t flg;
    } hres_t;

    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam half_t QNAN = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    // Round an 11-bit significand with guard/sticky, then pack with range checks.
    function automatic hres_t round_pack(input logic sgn, input sexp_t e,
                                         input logic [SIG_W-1:0] sig,
                                         input logic g, input logic st,
                                         input rmode_e rm);
        hres_t              r;
        logic               inc;
        logic               to_inf;
        logic [SIG_W:0]     s1;
        sexp_t              e1;
        r = '0;
        case (rm)
            RND_NEAR: inc = g & (st | sig[0]);
            RND_ZERO: inc = 1'b0;
            RND_POS:  inc = (g | st) & ~sgn;
            default:  inc = (g | st) & sgn;
        endcase
        s1 = {1'b0, sig} + (SIG_W+1)'(inc);
        e1 = e;
        if (s1[SIG_W]) begin
            e1 = e + sexp_t'(1);
            s1 = s1 >> 1;
        end
        r.flg.nx = g | st;
        to_inf = (rm == RND_NEAR) || (rm == RND_POS && !sgn) || (rm == RND_NEG && sgn);
        if (e1 >= sexp_t'(EXP_MAX)) begin
            r.flg.of = 1'b1;
            r.flg.nx = 1'b1;
            r.val = to_inf ? {sgn, EXP_ONES, {FRAC_W{1'b0}}}
                           : {sgn, EXP_ONES - EXP_W'(1), {FRAC_W{1'b1}}};
        end else if (e1 < sexp_t'(1)) begin
            r.flg.uf = 1'b1;
            r.flg.nx = 1'b1;
            r.val = {sgn, {(HW-1){1'b0}}};
        end else begin
            r.val = {sgn, e1[EXP_W-1:0], s1[FRAC_W-1:0]};
        end
        return r;
    endfunction

    // Count leading zeros of an alignment-width value.
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [ALN_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            found;
        n = '0;
        found = 1'b0;
        for (int i = ALN_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (v[i]) found = 1'b1;
                else      n = n + LZ_W'(1);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/cplx_hmul_fmul.sv
// Combinational half-precision multiplier for one partial product.
// Assumes subnormal inputs count as zero; NaN inputs yield the quiet NaN.
module cplx_hmul_fmul
    import cplx_hmul_pkg::*;
(
    input  half_t   op_a,
    input  half_t   op_b,
    input  rmode_e  rm,
    output half_t   prod,
    output hflags_t flg
);
    localparam int PW = 2 * SIG_W;

    logic               sa, sb, psgn;
    logic [EXP_W-1:0]   ea, eb;
    logic [FRAC_W-1:0]  fa, fb;
    logic               a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [PW-1:0]      pm;
    logic [SIG_W-1:0]   sig;
    logic               g, st;
    sexp_t              esum;
    hres_t              rp;

    // Field decode, significand product and special-case selection.
    always_comb begin
        sa = op_a[HW-1];  ea = op_a[HW-2 -: EXP_W];  fa = op_a[FRAC_W-1:0];
        sb = op_b[HW-1];  eb = op_b[HW-2 -: EXP_W];  fb = op_b[FRAC_W-1:0];
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        a_inf  = (ea == EXP_ONES) && (fa == '0);
        b_inf  = (eb == EXP_ONES) && (fb == '0);
        a_nan  = (ea == EXP_ONES) && (fa != '0);
        b_nan  = (eb == EXP_ONES) && (fb != '0);
        psgn   = sa ^ sb;
        pm     = {1'b1, fa} * {1'b1, fb};
        esum   = sexp_t'(ea) + sexp_t'(eb) - sexp_t'(BIAS);
        if (pm[PW-1]) begin
            esum = esum + sexp_t'(1);
            sig  = pm[PW-1 -: SIG_W];
            g    = pm[PW-1-SIG_W];
            st   = |pm[PW-2-SIG_W:0];
        end else begin
            sig  = pm[PW-2 -: SIG_W];
            g    = pm[PW-2-SIG_W];
            st   = |pm[PW-3-SIG_W:0];
        end
        rp   = round_pack(psgn, esum, sig, g, st, rm);
        prod = rp.val;
        flg  = rp.flg;
        if (a_nan || b_nan) begin
            prod = QNAN;
            flg  = '0;
        end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
            prod   = QNAN;
            flg    = '0;
            flg.nv = 1'b1;
        end else if (a_inf || b_inf) begin
            prod = {psgn, EXP_ONES, {FRAC_W{1'b0}}};
            flg  = '0;
        end else if (a_zero || b_zero) begin
            prod = {psgn, {(HW-1){1'b0}}};
            flg  = '0;
        end
    end

    // Checks on the product against its inputs.
    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R4
            if (!(prod[HW-2 -: EXP_W] == EXP_ONES && prod[FRAC_W-1:0] != '0))
                sign_xor_chk: assert (prod[HW-1] == (op_a[HW-1] ^ op_b[HW-1]));
            // R6
            if (flg.uf)
                flush_zero_chk: assert (prod[HW-2:0] == '0 && flg.nx);
            // R5
            if ((op_a[HW-2:0] == {EXP_ONES, {FRAC_W{1'b0}}} && op_b[HW-2 -: EXP_W] == '0) ||
                (op_b[HW-2:0] == {EXP_ONES, {FRAC_W{1'b0}}} && op_a[HW-2 -: EXP_W] == '0))
                inf_zero_nan_chk: assert (prod == QNAN && flg.nv);
        end
    end

endmodule

// File: rtl/cplx_hmul_fadd.sv
// Combinational half-precision adder/subtractor used for both result parts.
// Assumes subnormal inputs count as zero; aligns with a sticky-collapsed shift.
module cplx_hmul_fadd
    import cplx_hmul_pkg::*;
(
    input  half_t   op_a,
    input  half_t   op_b,
    input  logic    sub,
    input  rmode_e  rm,
    output half_t   sum,
    output hflags_t flg
);
    logic               sa, sb, sL, sS;
    logic [EXP_W-1:0]   ea, eb, eL, eS, dexp, dsh;
    logic [FRAC_W-1:0]  fa, fb, fL, fS;
    logic               a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [ALN_W-1:0]   bigv, smv, sm_al, nrm;
    logic [2*ALN_W-1:0] sh;
    logic [ALN_W:0]     r;
    logic [LZ_W-1:0]    lz;
    logic [SIG_W-1:0]   sig;
    logic               g, st;
    sexp_t              e;
    hres_t              rp;

    // Operand order, alignment, add/subtract, normalisation and specials.
    always_comb begin
        sa = op_a[HW-1];        ea = op_a[HW-2 -: EXP_W];  fa = op_a[FRAC_W-1:0];
        sb = op_b[HW-1] ^ sub;  eb = op_b[HW-2 -: EXP_W];  fb = op_b[FRAC_W-1:0];
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        a_inf  = (ea == EXP_ONES) && (fa == '0);
        b_inf  = (eb == EXP_ONES) && (fb == '0);
        a_nan  = (ea == EXP_ONES) && (fa != '0);
        b_nan  = (eb == EXP_ONES) && (fb != '0);
        if ({ea, fa} >= {eb, fb}) begin
            sL = sa; eL = ea; fL = fa; sS = sb; eS = eb; fS = fb;
        end else begin
            sL = sb; eL = eb; fL = fb; sS = sa; eS = ea; fS = fa;
        end
        dexp  = eL - eS;
        dsh   = (dexp > EXP_W'(ALN_W)) ? EXP_W'(ALN_W + 1) : dexp;
        bigv  = {1'b1, fL, {(ALN_W-SIG_W){1'b0}}};
        smv   = {1'b1, fS, {(ALN_W-SIG_W){1'b0}}};
        sh    = {smv, {ALN_W{1'b0}}} >> dsh;
        sm_al = sh[2*ALN_W-1:ALN_W] | {{(ALN_W-1){1'b0}}, |sh[ALN_W-1:0]};
        r     = (sL == sS) ? ({1'b0, bigv} + {1'b0, sm_al})
                           : ({1'b0, bigv} - {1'b0, sm_al});
        lz    = lead_zeros(r[ALN_W-1:0]);
        nrm   = r[ALN_W-1:0] << lz;
        if (r[ALN_W]) begin
            e   = sexp_t'(eL) + sexp_t'(1);
            sig = r[ALN_W -: SIG_W];
            g   = r[ALN_W-SIG_W];
            st  = |r[ALN_W-SIG_W-1:0];
        end else begin
            e   = sexp_t'(eL) - sexp_t'(lz);
            sig = nrm[ALN_W-1 -: SIG_W];
            g   = nrm[ALN_W-1-SIG_W];
            st  = |nrm[ALN_W-2-SIG_W:0];
        end
        rp  = round_pack(sL, e, sig, g, st, rm);
        sum = rp.val;
        flg = rp.flg;
        if (a_nan || b_nan) begin
            sum = QNAN;
            flg = '0;
        end else if (a_inf && b_inf && (sa != sb)) begin
            sum    = QNAN;
            flg    = '0;
            flg.nv = 1'b1;
        end else if (a_inf) begin
            sum = {sa, EXP_ONES, {FRAC_W{1'b0}}};
            flg = '0;
        end else if (b_inf) begin
            sum = {sb, EXP_ONES, {FRAC_W{1'b0}}};
            flg = '0;
        end else if (a_zero && b_zero) begin
            sum = {(sa == sb) ? sa : (rm == RND_NEG), {(HW-1){1'b0}}};
            flg = '0;
        end else if (a_zero) begin
            sum = {sb, op_b[HW-2:0]};
            flg = '0;
        end else if (b_zero) begin
            sum = op_a;
            flg = '0;
        end else if (r == '0) begin
            sum = {rm == RND_NEG, {(HW-1){1'b0}}};
            flg = '0;
        end
    end

    // Identity check: a zero second operand leaves a finite first operand intact.
    always_comb begin
        // R2
        if (!$isunknown({op_a, op_b}) && op_b[HW-2 -: EXP_W] == '0 &&
            op_a[HW-2 -: EXP_W] != '0 && op_a[HW-2 -: EXP_W] != EXP_ONES)
            add_zero_ident_chk: assert (sum == op_a && flg == '0);
    end

endmodule

// File: rtl/cplx_hmul.sv
// Complex half-precision multiplier: sequences ac, bd, ad, bc through one
// multiplier, then ac-bd and ad+bc through one adder. Six cycles per request.
// Assumes start is sampled only while idle.
module cplx_hmul
    import cplx_hmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2*HW-1:0]   op_x,
    input  logic [2*HW-1:0]   op_y,
    input  logic [1:0]        rnd_mode,
    output logic              busy,
    output logic              done,
    output logic [2*HW-1:0]   result,
    output logic [3:0]        flags
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_AC, ST_BD, ST_AD, ST_BC, ST_RE, ST_IM
    } step_e;

    step_e          state;
    logic [2*HW-1:0] x_q, y_q;
    rmode_e         rm_q;
    half_t          p_ac, p_bd, p_ad, p_bc, re_q;
    logic [3:0]     acc;
    half_t          m_a, m_b, m_y, s_a, s_b, s_y;
    logic           s_sub;
    hflags_t        m_flg, s_flg;

    assign busy = (state != ST_IDLE);

    // Select the multiplier operands for the current product step.
    always_comb begin
        m_a = x_q[2*HW-1:HW];
        m_b = y_q[2*HW-1:HW];
        case (state)
            ST_BD: begin m_a = x_q[HW-1:0];    m_b = y_q[HW-1:0];    end
            ST_AD: begin m_a = x_q[2*HW-1:HW]; m_b = y_q[HW-1:0];    end
            ST_BC: begin m_a = x_q[HW-1:0];    m_b = y_q[2*HW-1:HW]; end
            default: ;
        endcase
    end

    // Select the adder operands: real part subtracts, imaginary part adds.
    always_comb begin
        s_a   = (state == ST_RE) ? p_ac : p_ad;
        s_b   = (state == ST_RE) ? p_bd : p_bc;
        s_sub = (state == ST_RE);
    end

    cplx_hmul_fmul u_fmul (
        .op_a (m_a),
        .op_b (m_b),
        .rm   (rm_q),
        .prod (m_y),
        .flg  (m_flg)
    );

    cplx_hmul_fadd u_fadd (
        .op_a (s_a),
        .op_b (s_b),
        .sub  (s_sub),
        .rm   (rm_q),
        .sum  (s_y),
        .flg  (s_flg)
    );

    // Step sequencer with operand capture, partial storage and flag accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            x_q    <= '0;
            y_q    <= '0;
            rm_q   <= RND_NEAR;
            p_ac   <= '0;
            p_bd   <= '0;
            p_ad   <= '0;
            p_bc   <= '0;
            re_q   <= '0;
            acc    <= '0;
            done   <= 1'b0;
            result <= '0;
            flags  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    x_q   <= op_x;
                    y_q   <= op_y;
                    rm_q  <= rmode_e'(rnd_mode);
                    acc   <= '0;
                    state <= ST_AC;
                end
                ST_AC: begin p_ac <= m_y; acc <= acc | m_flg; state <= ST_BD; end
                ST_BD: begin p_bd <= m_y; acc <= acc | m_flg; state <= ST_AD; end
                ST_AD: begin p_ad <= m_y; acc <= acc | m_flg; state <= ST_BC; end
                ST_BC: begin p_bc <= m_y; acc <= acc | m_flg; state <= ST_RE; end
                ST_RE: begin re_q <= s_y; acc <= acc | s_flg; state <= ST_IM; end
                ST_IM: begin
                    result <= {re_q, s_y};
                    flags  <= acc | s_flg;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_im_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_IM) && !busy);

    // R10
    hold_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(x_q) && $stable(y_q) && $stable(rm_q));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(flags));

endmodule

// File: tb/cplx_hmul_tb_top.sv
module cplx_hmul_tb_top;

    localparam int NV  = 16;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_x = '0;
    logic [31:0] op_y = '0;
    logic [1:0]  rnd_mode = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cplx_hmul dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_x     (op_x),
        .op_y     (op_y),
        .rnd_mode (rnd_mode),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .flags    (flags)
    );

    // {op_x, op_y, mode, expected result, expected flags {nv,of,uf,nx}}
    localparam logic [101:0] VEC [0:NV-1] = '{
        {32'h4600_4500, 32'h4900_4480, 2'd0, 32'h50B0_54D0, 4'b0000}, // R2 worked example
        {32'h3C00_0000, 32'h4200_C000, 2'd0, 32'h4200_C000, 4'b0000}, // R1 unit times value
        {32'h0000_3C00, 32'h0000_3C00, 2'd0, 32'hBC00_0000, 4'b0000}, // R4 j*j = -1
        {32'hC000_4200, 32'hC400_BC00, 2'd0, 32'h4980_C900, 4'b0000}, // R4 mixed signs
        {32'h7C00_0000, 32'h0000_3C00, 2'd0, 32'h7E00_7C00, 4'b1000}, // R5 inf*0
        {32'h7E00_3C00, 32'h3C00_0000, 2'd0, 32'h7E00_7E00, 4'b0000}, // R5 NaN propagates
        {32'h3C01_0000, 32'h3C01_0000, 2'd0, 32'h3C02_0000, 4'b0001}, // R3 product nearest
        {32'h3C01_0000, 32'h3C01_0000, 2'd1, 32'h3C02_0000, 4'b0001}, // R3 product to zero
        {32'h3C01_0000, 32'h3C01_0000, 2'd2, 32'h3C03_0000, 4'b0001}, // R3 product to +inf
        {32'hBC01_0000, 32'h3C01_0000, 2'd3, 32'hBC03_8000, 4'b0001}, // R3 to -inf, -0 sum
        {32'h3C00_1000, 32'h3C00_3C00, 2'd0, 32'h3BFF_3C00, 4'b0001}, // R3 adder tie even
        {32'h3C00_1000, 32'h3C00_3C00, 2'd2, 32'h3BFF_3C01, 4'b0001}, // R3 adder up
        {32'h7800_0000, 32'h7800_0000, 2'd0, 32'h7C00_0000, 4'b0101}, // R7 overflow to inf
        {32'h7800_0000, 32'h7800_0000, 2'd1, 32'h7BFF_0000, 4'b0101}, // R7 overflow to max
        {32'h0400_0000, 32'h3800_0000, 2'd0, 32'h0000_0000, 4'b0011}, // R6 underflow flush
        {32'h0001_0000, 32'h3C00_0000, 2'd0, 32'h0000_0000, 4'b0000}  // R6 subnormal as zero
    };

    localparam string TAG [0:NV-1] = '{
        "R2", "R1", "R4", "R4", "R5", "R5", "R3", "R3",
        "R3", "R3", "R3", "R3", "R7", "R7", "R6", "R6"
    };

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Issue one request; return the edges from acceptance to done.
    task automatic run_op(input logic [31:0] x, input logic [31:0] y,
                          input logic [1:0] m, output int lat);
        @(negedge clk);
        op_x = x; op_y = y; rnd_mode = m; start = 1'b1;
        @(posedge clk);
        lat = 0;
        while (lat < 30) begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "busy",   64'(busy),   64'd0);
        check("R11", "done",   64'(done),   64'd0);
        check("R11", "result", 64'(result), 64'd0);
        check("R11", "flags",  64'(flags),  64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][101:70], VEC[i][69:38], VEC[i][37:36], lat);
            check(TAG[i], "result", 64'(result), 64'(VEC[i][35:4]));
            // R8 flags
            check(TAG[i], "flags", 64'(flags), 64'(VEC[i][3:0]));
            if (i == 0) begin
                // R9 latency, pulse width and busy release
                check("R9", "latency", 64'(lat), 64'(LAT));
                check("R9", "busy at done", 64'(busy), 64'd0);
                @(negedge clk);
                check("R9", "done width", 64'(done), 64'd0);
            end
        end

        // R10 start while busy is ignored
        run_op(32'h3C00_0000, 32'h4200_C000, 2'd0, lat);
        @(negedge clk);
        op_x = 32'h4600_4500; op_y = 32'h4900_4480; rnd_mode = 2'd0; start = 1'b1;
        @(posedge clk);
        lat = 0;
        while (lat < 30) begin
            @(negedge clk);
            if (lat == 2) begin
                op_x = 32'h7800_0000; op_y = 32'h7800_0000; rnd_mode = 2'd1;
            end else begin
                start = (lat == 1);
            end
            if (done) break;
            lat++;
        end
        start = 1'b0;
        check("R10", "latency", 64'(lat), 64'(LAT));
        check("R10", "result", 64'(result), 64'h50B0_54D0);
        check("R10", "flags", 64'(flags), 64'd0);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R10", "extra activity", 64'(extra), 64'd0);
        end
        check("R10", "result held", 64'(result), 64'h50B0_54D0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: actual no completion expected completion");
            summary();
            $finish;
        end
    end

endmodule